// File: doc/BRIEF.md
# Mixed-Criticality Task Scheduler

This block is a scheduling coprocessor. It keeps a small table of task entries and, every clock cycle, names the one task that should run. Each entry carries a criticality class, a period, an absolute deadline and an arrival stamp. Three classes exist. Hard real-time work always outranks soft real-time work, and soft real-time work always outranks non real-time work. Inside a class, a policy specific to that class picks the winner. Hard tasks go earliest deadline first. Soft tasks go shortest period first. Non real-time tasks are served in arrival order.

Software configures entries, activates them and retires them. Activations may also come from a timer vector or from an external event vector. No task can be blocked or suspended. A sleeping task is simply an entry that is not ready until something activates it again. The block reports its choice through a registered task ID and a valid flag. It also raises a one-cycle preemption request when the choice displaces a task that is still ready. A small bank of binary semaphores answers take and give requests. A failed take is reported back to the caller and does not block anything.

Top module: `mc_task_sched`

## Requirements
- R1: After reset, sel_valid, sel_id, preempt, sem_ack and every bit of sem_locked are 0, and no task is ready.
- R2: Class codes are 0 for non real-time, 1 for soft real-time and 2 for hard real-time. Code 3 is stored as 0. Any ready task of a higher class wins over every ready task of a lower class.
- R3: A ready non real-time task is stamped with an arrival number when it turns ready, and the smallest stamp wins. Activating a task that is already ready keeps its stamp.
- R4: Among ready soft real-time tasks, the one with the smallest period wins.
- R5: Among ready hard real-time tasks, the one with the smallest unsigned absolute deadline wins.
- R6: Equal keys within a class go to the lowest task index. Tasks activated in the same cycle receive the same stamp.
- R7: A task turns ready from a software activation, a timer vector bit or an event vector bit. An activation aimed at an entry that is not valid is ignored.
- R8: A completion clears ready. An activation in the same cycle overrides the completion. A configuration write with valid 0 removes the task and clears its ready flag.
- R9: A table change made at clock edge k appears on sel_valid and sel_id after edge k+1.
- R10: When no task is ready, sel_valid is 0 and sel_id is 0.
- R11: preempt is high for one cycle when a newly selected task replaces a previous selection that is still ready.
- R12: A take on a free semaphore locks it to the requesting task and returns sem_ok=1 with sem_ack on the next cycle. A take on a locked semaphore returns sem_ok=0 and changes neither the locks nor any task state.
- R13: A give from the owner frees the semaphore with sem_ok=1. A give from any other task, or on a free semaphore, returns sem_ok=0 and changes nothing.
- R14: A configuration write with valid 1 on a ready task keeps it ready and keeps its stamp. The new class, period and deadline take effect in the next selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Write one table entry |
| cfg_id | input | 3 | Entry being written |
| cfg_valid | input | 1 | 1 keeps or creates the task, 0 removes it |
| cfg_class | input | 2 | Criticality class code |
| cfg_period | input | 16 | Period used by the soft class |
| cfg_deadline | input | 32 | Absolute deadline used by the hard class |
| act_we | input | 1 | Software activation strobe |
| act_id | input | 3 | Task activated by software |
| done_we | input | 1 | Completion strobe |
| done_id | input | 3 | Task that completed |
| tmr_act | input | 8 | Timer activations, one bit per task |
| evt_act | input | 8 | External event activations, one bit per task |
| sem_req | input | 1 | Semaphore request strobe |
| sem_release | input | 1 | 1 for a give, 0 for a take |
| sem_idx | input | 2 | Semaphore addressed |
| sem_tid | input | 3 | Task making the request |
| sel_valid | output | 1 | A task is selected |
| sel_id | output | 3 | Selected task, 0 when idle |
| preempt | output | 1 | One-cycle preemption request |
| sem_ack | output | 1 | Reply to the previous cycle's request |
| sem_ok | output | 1 | Request succeeded |
| sem_locked | output | 4 | Lock state of each semaphore |

## Verification
Several properties are checked by assertions on every cycle. A completion that meets no activation clears ready. A newly ready entry captures the arrival counter. An idle output reports ID 0. Every selected task was ready in the cycle before. A preemption always coincides with a real change of selection. A refused take or a foreign give leaves all locks untouched. Other behaviour can only be shown by the bench's scenarios. This covers the policy orderings within each class, the ranking between classes, tie-breaking by index, the folding of class code 3, and activations arriving from several sources at once. To cover these, the bench runs a directed sequence and then a long pseudo-random sweep. Both are compared against an arithmetic model of the table.

// File: rtl/mcs_pkg.sv
`timescale 1ns/1ps
// Package: shared class encoding and helpers for the task scheduler.
// Assumes class codes are 2 bits wide; code 3 is folded into non real-time.
package mcs_pkg;

    typedef enum logic [1:0] {
        CLS_NRT = 2'd0,
        CLS_SRT = 2'd1,
        CLS_HRT = 2'd2
    } task_class_e;

    // Fold a raw class code onto the three legal classes.
    function automatic logic [1:0] norm_class(input logic [1:0] raw);
        return (raw == 2'd3) ? 2'(CLS_NRT) : raw;
    endfunction

    // Distance from the top class: 0 for hard, 1 for soft, 2 for non real-time.
    function automatic logic [1:0] class_gap(input logic [1:0] cls);
        case (task_class_e'(cls))
            CLS_HRT: return 2'd0;
            CLS_SRT: return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/mcs_task_table.sv
`timescale 1ns/1ps
// Module: task entry storage. Holds valid, ready, class, period, deadline and
// the arrival stamp of every task, and the free-running arrival counter.
// Assumes: a configuration write has priority over activation and completion
// of the same entry. An activation has priority over a completion.
module mcs_task_table
    import mcs_pkg::*;
#(
    parameter int NUM_TASKS = 8,
    parameter int PERIOD_W  = 16,
    parameter int DL_W      = 32,
    parameter int SEQ_W     = 16,
    localparam int ID_W     = $clog2(NUM_TASKS)
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 cfg_we,
    input  logic [ID_W-1:0]                      cfg_id,
    input  logic                                 cfg_valid,
    input  logic [1:0]                           cfg_class,
    input  logic [PERIOD_W-1:0]                  cfg_period,
    input  logic [DL_W-1:0]                      cfg_deadline,
    input  logic [NUM_TASKS-1:0]                 act_vec,
    input  logic                                 done_we,
    input  logic [ID_W-1:0]                      done_id,
    output logic [NUM_TASKS-1:0]                 ready_o,
    output logic [NUM_TASKS-1:0][1:0]            cls_o,
    output logic [NUM_TASKS-1:0][PERIOD_W-1:0]   period_o,
    output logic [NUM_TASKS-1:0][DL_W-1:0]       dl_o,
    output logic [NUM_TASKS-1:0][SEQ_W-1:0]      seq_o
);

    logic [NUM_TASKS-1:0] valid_q;
    logic [NUM_TASKS-1:0] ready_q;
    logic [NUM_TASKS-1:0] cfg_hit;
    logic [NUM_TASKS-1:0] done_hit;
    logic [NUM_TASKS-1:0] fresh;
    logic [SEQ_W-1:0]     seq_cnt;

    // Decode the write and completion targets into one-hot vectors.
    always_comb begin
        for (int i = 0; i < NUM_TASKS; i++) begin
            cfg_hit[i]  = cfg_we  && (cfg_id  == ID_W'(i));
            done_hit[i] = done_we && (done_id == ID_W'(i));
        end
    end

    // Entries that go from idle to ready this cycle and take a new stamp.
    assign fresh = act_vec & valid_q & ~ready_q & ~cfg_hit;

    // Arrival counter: advances once per cycle that has any new arrival.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_cnt <= '0;
        end else if (|fresh) begin
            seq_cnt <= seq_cnt + 1'b1;
        end
    end

    for (genvar g = 0; g < NUM_TASKS; g++) begin : g_entry
        // Per-entry update: configuration first, then activation, then completion.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g]  <= 1'b0;
                ready_q[g]  <= 1'b0;
                cls_o[g]    <= 2'(CLS_NRT);
                period_o[g] <= '0;
                dl_o[g]     <= '0;
                seq_o[g]    <= '0;
            end else if (cfg_hit[g]) begin
                valid_q[g]  <= cfg_valid;
                ready_q[g]  <= ready_q[g] & cfg_valid;
                cls_o[g]    <= norm_class(cfg_class);
                period_o[g] <= cfg_period;
                dl_o[g]     <= cfg_deadline;
            end else if (act_vec[g] && valid_q[g]) begin
                ready_q[g] <= 1'b1;
                if (fresh[g]) begin
                    seq_o[g] <= seq_cnt;
                end
            end else if (done_hit[g]) begin
                ready_q[g] <= 1'b0;
            end
        end

        // R8: a completion that meets no activation or write clears ready.
        assert_done_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (done_hit[g] && !act_vec[g] && !cfg_hit[g]) |=> !ready_q[g]);

        // R3: a newly ready entry holds the counter value it arrived with.
        assert_fresh_stamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
            fresh[g] |=> (ready_q[g] && seq_o[g] == $past(seq_cnt)));
    end

    assign ready_o = ready_q;

endmodule

// File: rtl/mcs_pick.sv
`timescale 1ns/1ps
// Module: combinational winner selection. Builds one ordering key per task
// (class distance above the class metric) and scans for the smallest key.
// Assumes: only ready tasks compete. Equal keys keep the lowest index
// because the scan replaces the best only on a strictly smaller key.
module mcs_pick
    import mcs_pkg::*;
#(
    parameter int NUM_TASKS = 8,
    parameter int PERIOD_W  = 16,
    parameter int DL_W      = 32,
    parameter int SEQ_W     = 16,
    localparam int ID_W     = $clog2(NUM_TASKS),
    localparam int MET_W    = (DL_W > PERIOD_W) ? ((DL_W > SEQ_W) ? DL_W : SEQ_W)
                                                : ((PERIOD_W > SEQ_W) ? PERIOD_W : SEQ_W),
    localparam int KEY_W    = MET_W + 2
) (
    input  logic [NUM_TASKS-1:0]                 ready_i,
    input  logic [NUM_TASKS-1:0][1:0]            cls_i,
    input  logic [NUM_TASKS-1:0][PERIOD_W-1:0]   period_i,
    input  logic [NUM_TASKS-1:0][DL_W-1:0]       dl_i,
    input  logic [NUM_TASKS-1:0][SEQ_W-1:0]      seq_i,
    output logic                                 win_valid_o,
    output logic [ID_W-1:0]                      win_id_o
);

    logic [KEY_W-1:0] key [NUM_TASKS];

    for (genvar g = 0; g < NUM_TASKS; g++) begin : g_key
        // Key of one task: class distance, then the metric its class uses.
        always_comb begin
            case (task_class_e'(cls_i[g]))
                CLS_HRT: key[g] = {class_gap(cls_i[g]), MET_W'(dl_i[g])};
                CLS_SRT: key[g] = {class_gap(cls_i[g]), MET_W'(period_i[g])};
                default: key[g] = {class_gap(cls_i[g]), MET_W'(seq_i[g])};
            endcase
        end
    end

    // Linear scan for the smallest key among the ready tasks.
    always_comb begin
        logic [KEY_W-1:0] best;
        best        = '1;
        win_valid_o = 1'b0;
        win_id_o    = '0;
        for (int i = 0; i < NUM_TASKS; i++) begin
            if (ready_i[i] && (!win_valid_o || key[i] < best)) begin
                win_valid_o = 1'b1;
                best        = key[i];
                win_id_o    = ID_W'(i);
            end
        end
    end

endmodule

// File: rtl/mcs_dispatch.sv
`timescale 1ns/1ps
// Module: registers the winner as the dispatched task and raises the
// preemption pulse when the winner displaces a task that is still ready.
// Assumes: the winner and the ready vector come from the same table state.
module mcs_dispatch #(
    parameter int NUM_TASKS = 8,
    localparam int ID_W     = $clog2(NUM_TASKS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  win_valid_i,
    input  logic [ID_W-1:0]       win_id_i,
    input  logic [NUM_TASKS-1:0]  ready_i,
    output logic                  sel_valid_o,
    output logic [ID_W-1:0]       sel_id_o,
    output logic                  preempt_o
);

    // Selection register with idle ID 0 and the displacement pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_valid_o <= 1'b0;
            sel_id_o    <= '0;
            preempt_o   <= 1'b0;
        end else begin
            sel_valid_o <= win_valid_i;
            sel_id_o    <= win_valid_i ? win_id_i : '0;
            preempt_o   <= win_valid_i && sel_valid_o && ready_i[sel_id_o]
                           && (win_id_i != sel_id_o);
        end
    end

    // R10: an idle selection always reports task 0.
    assert_idle_id_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid_o |-> (sel_id_o == '0));

    // R11: a preemption always replaces an earlier valid selection.
    assert_preempt_displace_R11: assert property (@(posedge clk) disable iff (!rst_n)
        preempt_o |-> (sel_valid_o && $past(sel_valid_o) && sel_id_o != $past(sel_id_o)));

    // R9: the dispatched task was ready in the table one cycle earlier.
    assert_sel_was_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid_o |-> (1'(($past(ready_i) >> sel_id_o)) == 1'b1));

endmodule

// File: rtl/mcs_sem_unit.sv
`timescale 1ns/1ps
// Module: bank of binary semaphores with owner tracking. A take on a free
// semaphore locks it to the caller. Give frees it only for the owner. A
// refused request only reports failure and never holds the caller.
// Assumes: sem_idx addresses an existing semaphore.
module mcs_sem_unit #(
    parameter int NUM_SEMS  = 4,
    parameter int ID_W      = 3,
    localparam int SI_W     = (NUM_SEMS > 1) ? $clog2(NUM_SEMS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_i,
    input  logic                 release_i,
    input  logic [SI_W-1:0]      idx_i,
    input  logic [ID_W-1:0]      tid_i,
    output logic                 ack_o,
    output logic                 ok_o,
    output logic [NUM_SEMS-1:0]  locked_o
);

    logic [NUM_SEMS-1:0][ID_W-1:0] owner_q;

    // Serve one take or give per cycle and answer on the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_o    <= 1'b0;
            ok_o     <= 1'b0;
            locked_o <= '0;
            owner_q  <= '0;
        end else begin
            ack_o <= req_i;
            ok_o  <= 1'b0;
            if (req_i && !release_i) begin
                if (!locked_o[idx_i]) begin
                    locked_o[idx_i] <= 1'b1;
                    owner_q[idx_i]  <= tid_i;
                    ok_o            <= 1'b1;
                end
            end else if (req_i && release_i) begin
                if (locked_o[idx_i] && owner_q[idx_i] == tid_i) begin
                    locked_o[idx_i] <= 1'b0;
                    ok_o            <= 1'b1;
                end
            end
        end
    end

    // R12: a take on a held semaphore fails and leaves every lock as it was.
    assert_busy_take_fails_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !release_i && locked_o[idx_i]) |=> (ack_o && !ok_o && $stable(locked_o)));

    // R13: a give from a non-owner fails and leaves every lock as it was.
    assert_foreign_give_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && release_i && (!locked_o[idx_i] || owner_q[idx_i] != tid_i))
        |=> (ack_o && !ok_o && $stable(locked_o)));

    // R12: success is only reported together with an acknowledge.
    assert_ok_has_ack_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ok_o |-> ack_o);

endmodule

// File: rtl/mc_task_sched.sv
`timescale 1ns/1ps
// Module: top of the mixed-criticality task scheduler. Merges the three
// activation sources, keeps the task table, picks the winner and registers
// the dispatch, and hosts the semaphore bank.
// Assumes: the arrival stamp does not wrap within the lifetime of a ready task.
module mc_task_sched #(
    parameter int NUM_TASKS = 8,
    parameter int PERIOD_W  = 16,
    parameter int DL_W      = 32,
    parameter int SEQ_W     = 16,
    parameter int NUM_SEMS  = 4,
    localparam int ID_W     = $clog2(NUM_TASKS),
    localparam int SI_W     = (NUM_SEMS > 1) ? $clog2(NUM_SEMS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [ID_W-1:0]       cfg_id,
    input  logic                  cfg_valid,
    input  logic [1:0]            cfg_class,
    input  logic [PERIOD_W-1:0]   cfg_period,
    input  logic [DL_W-1:0]       cfg_deadline,
    input  logic                  act_we,
    input  logic [ID_W-1:0]       act_id,
    input  logic                  done_we,
    input  logic [ID_W-1:0]       done_id,
    input  logic [NUM_TASKS-1:0]  tmr_act,
    input  logic [NUM_TASKS-1:0]  evt_act,
    input  logic                  sem_req,
    input  logic                  sem_release,
    input  logic [SI_W-1:0]       sem_idx,
    input  logic [ID_W-1:0]       sem_tid,
    output logic                  sel_valid,
    output logic [ID_W-1:0]       sel_id,
    output logic                  preempt,
    output logic                  sem_ack,
    output logic                  sem_ok,
    output logic [NUM_SEMS-1:0]   sem_locked
);

    logic [NUM_TASKS-1:0]                act_vec;
    logic [NUM_TASKS-1:0]                ready;
    logic [NUM_TASKS-1:0][1:0]           cls;
    logic [NUM_TASKS-1:0][PERIOD_W-1:0]  period;
    logic [NUM_TASKS-1:0][DL_W-1:0]      deadline;
    logic [NUM_TASKS-1:0][SEQ_W-1:0]     seq;
    logic                                win_valid;
    logic [ID_W-1:0]                     win_id;

    // Merge software, timer and event activations into one vector.
    always_comb begin
        act_vec = tmr_act | evt_act;
        if (act_we) begin
            act_vec[act_id] = 1'b1;
        end
    end

    mcs_task_table #(
        .NUM_TASKS (NUM_TASKS),
        .PERIOD_W  (PERIOD_W),
        .DL_W      (DL_W),
        .SEQ_W     (SEQ_W)
    ) table_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_id       (cfg_id),
        .cfg_valid    (cfg_valid),
        .cfg_class    (cfg_class),
        .cfg_period   (cfg_period),
        .cfg_deadline (cfg_deadline),
        .act_vec      (act_vec),
        .done_we      (done_we),
        .done_id      (done_id),
        .ready_o      (ready),
        .cls_o        (cls),
        .period_o     (period),
        .dl_o         (deadline),
        .seq_o        (seq)
    );

    mcs_pick #(
        .NUM_TASKS (NUM_TASKS),
        .PERIOD_W  (PERIOD_W),
        .DL_W      (DL_W),
        .SEQ_W     (SEQ_W)
    ) pick_i (
        .ready_i     (ready),
        .cls_i       (cls),
        .period_i    (period),
        .dl_i        (deadline),
        .seq_i       (seq),
        .win_valid_o (win_valid),
        .win_id_o    (win_id)
    );

    mcs_dispatch #(
        .NUM_TASKS (NUM_TASKS)
    ) dispatch_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .win_valid_i (win_valid),
        .win_id_i    (win_id),
        .ready_i     (ready),
        .sel_valid_o (sel_valid),
        .sel_id_o    (sel_id),
        .preempt_o   (preempt)
    );

    mcs_sem_unit #(
        .NUM_SEMS (NUM_SEMS),
        .ID_W     (ID_W)
    ) sem_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (sem_req),
        .release_i (sem_release),
        .idx_i     (sem_idx),
        .tid_i     (sem_tid),
        .ack_o     (sem_ack),
        .ok_o      (sem_ok),
        .locked_o  (sem_locked)
    );

endmodule

// File: tb/mc_task_sched_tb_top.sv
`timescale 1ns/1ps
// Bench: directed scenarios plus a pseudo-random sweep, all compared with an
// arithmetic model of the task table kept inside the bench.
module mc_task_sched_tb_top;

    localparam int N  = 8;
    localparam int NS = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we, cfg_valid, act_we, done_we, sem_req, sem_release;
    logic [2:0]  cfg_id, act_id, done_id, sem_tid;
    logic [1:0]  cfg_class, sem_idx;
    logic [15:0] cfg_period;
    logic [31:0] cfg_deadline;
    logic [N-1:0] tmr_act, evt_act;
    logic        sel_valid, preempt, sem_ack, sem_ok;
    logic [2:0]  sel_id;
    logic [NS-1:0] sem_locked;

    int n_vec = 0;
    int n_bad = 0;

    // Bench model of the table.
    bit          mv [N];
    bit          mr [N];
    logic [1:0]  mc [N];
    logic [15:0] mp [N];
    logic [31:0] md [N];
    int          ms [N];
    int          mcnt;
    bit          prev_v, exp_v, exp_pre;
    int          prev_id, exp_id;
    logic [31:0] lfsr = 32'h1d2c_3b4a;

    always #10 clk = ~clk;

    mc_task_sched dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_id(cfg_id), .cfg_valid(cfg_valid), .cfg_class(cfg_class),
        .cfg_period(cfg_period), .cfg_deadline(cfg_deadline),
        .act_we(act_we), .act_id(act_id), .done_we(done_we), .done_id(done_id),
        .tmr_act(tmr_act), .evt_act(evt_act),
        .sem_req(sem_req), .sem_release(sem_release), .sem_idx(sem_idx), .sem_tid(sem_tid),
        .sel_valid(sel_valid), .sel_id(sel_id), .preempt(preempt),
        .sem_ack(sem_ack), .sem_ok(sem_ok), .sem_locked(sem_locked)
    );

    task automatic clear_inputs();
        cfg_we = 0; cfg_id = 0; cfg_valid = 0; cfg_class = 0; cfg_period = 0; cfg_deadline = 0;
        act_we = 0; act_id = 0; done_we = 0; done_id = 0; tmr_act = 0; evt_act = 0;
        sem_req = 0; sem_release = 0; sem_idx = 0; sem_tid = 0;
    endtask

    function automatic longint key_of(int i);
        longint gap;
        longint met;
        if (mc[i] == 2'd2) begin gap = 0; met = longint'(md[i]); end
        else if (mc[i] == 2'd1) begin gap = 1; met = longint'(mp[i]); end
        else begin gap = 2; met = longint'(ms[i]); end
        return (gap << 40) + met;
    endfunction

    // Model update from the inputs currently driven, then the expected outputs.
    task automatic model_apply();
        bit [N-1:0] av;
        bit [N-1:0] fresh;
        bit hit;
        longint best;
        av = tmr_act | evt_act;
        if (act_we) av[act_id] = 1'b1;
        for (int i = 0; i < N; i++) begin
            hit = cfg_we && (cfg_id == 3'(i));
            fresh[i] = av[i] && mv[i] && !mr[i] && !hit;
        end
        for (int i = 0; i < N; i++) begin
            hit = cfg_we && (cfg_id == 3'(i));
            if (hit) begin
                mv[i] = cfg_valid;
                mr[i] = mr[i] && cfg_valid;
                mc[i] = (cfg_class == 2'd3) ? 2'd0 : cfg_class;
                mp[i] = cfg_period;
                md[i] = cfg_deadline;
            end else if (av[i] && mv[i]) begin
                if (fresh[i]) ms[i] = mcnt;
                mr[i] = 1'b1;
            end else if (done_we && done_id == 3'(i)) begin
                mr[i] = 1'b0;
            end
        end
        if (|fresh) mcnt++;
        exp_v = 0; exp_id = 0; best = 0;
        for (int i = 0; i < N; i++) begin
            if (mr[i] && (!exp_v || key_of(i) < best)) begin
                exp_v = 1; exp_id = i; best = key_of(i);
            end
        end
        exp_pre = exp_v && prev_v && mr[prev_id] && (exp_id != prev_id);
    endtask

    task automatic compare(string tag, bit v, int id, bit pre);
        n_vec++;
        if (sel_valid !== v || int'(sel_id) != id || preempt !== pre) begin
            n_bad++;
            $display("FAIL %s: got valid=%0b id=%0d preempt=%0b, expected valid=%0b id=%0d preempt=%0b",
                     tag, sel_valid, sel_id, preempt, v, id, pre);
        end
    endtask

    // Apply the driven inputs for one edge, idle one edge, compare with the model.
    task automatic run_op(string tag);
        model_apply();
        @(posedge clk);
        @(negedge clk);
        clear_inputs();
        @(posedge clk);
        @(negedge clk);
        compare(tag, exp_v, exp_id, exp_pre);
        prev_v = exp_v;
        prev_id = exp_id;
    endtask

    task automatic cfg(int id, bit v, int c, int per, int dl);
        cfg_we = 1; cfg_id = 3'(id); cfg_valid = v; cfg_class = 2'(c);
        cfg_period = 16'(per); cfg_deadline = 32'(dl);
        run_op("R14 cfg");
    endtask

    task automatic act(int id);
        act_we = 1; act_id = 3'(id);
        run_op("R7 act");
    endtask

    task automatic done(int id);
        done_we = 1; done_id = 3'(id);
        run_op("R8 done");
    endtask

    task automatic sem_op(string tag, bit rel, int idx, int tid, bit eok, logic [NS-1:0] elock);
        @(negedge clk);
        sem_req = 1; sem_release = rel; sem_idx = 2'(idx); sem_tid = 3'(tid);
        @(posedge clk);
        @(negedge clk);
        clear_inputs();
        n_vec++;
        if (sem_ack !== 1'b1 || sem_ok !== eok || sem_locked !== elock) begin
            n_bad++;
            $display("FAIL %s: got ack=%0b ok=%0b locked=%b, expected ack=1 ok=%0b locked=%b",
                     tag, sem_ack, sem_ok, sem_locked, eok, elock);
        end
    endtask

    function automatic logic [31:0] next_rand();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return lfsr;
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R9 watchdog: got no completion, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [31:0] r2;
        clear_inputs();
        for (int i = 0; i < N; i++) begin
            mv[i] = 0; mr[i] = 0; mc[i] = 0; mp[i] = 0; md[i] = 0; ms[i] = 0;
        end
        mcnt = 0; prev_v = 0; prev_id = 0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(posedge clk);
        @(negedge clk);
        // R1: reset state
        n_vec++;
        if (sel_valid !== 0 || sel_id !== 0 || preempt !== 0 || sem_ack !== 0 || sem_locked !== 0) begin
            n_bad++;
            $display("FAIL R1: got valid=%0b id=%0d preempt=%0b ack=%0b locked=%b, expected all zero",
                     sel_valid, sel_id, preempt, sem_ack, sem_locked);
        end

        for (int i = 0; i < N; i++) cfg(i, 1, 0, 100, 1000);
        compare("R10 idle", 0, 0, 0);

        // R3: arrival order among non real-time tasks
        act(5); compare("R3", 1, 5, 0);
        act(2); compare("R3", 1, 5, 0);
        act(7); compare("R3", 1, 5, 0);
        done(5); compare("R3", 1, 2, 0);
        act(1);
        act(7);
        done(2); compare("R3 stamp kept", 1, 7, 0);

        // R2, R11: soft class outranks non real-time and preempts
        cfg(3, 1, 1, 50, 1000); compare("R7 cfg no activation", 1, 7, 0);
        act(3); compare("R11 preempt", 1, 3, 1);
        run_op("R11 pulse"); compare("R11 pulse ends", 1, 3, 0);
        cfg(4, 1, 1, 20, 1000);
        act(4); compare("R4", 1, 4, 1);
        cfg(6, 1, 1, 20, 1000);
        act(6); compare("R6 srt tie", 1, 4, 0);

        // R5: earliest deadline among hard tasks
        cfg(0, 1, 2, 100, 1000);
        act(0); compare("R2 hard over soft", 1, 0, 1);
        cfg(1, 1, 2, 100, 500); compare("R14 ready kept", 1, 1, 1);
        cfg(0, 1, 2, 100, 500); compare("R6 hrt tie", 1, 0, 1);
        cfg(1, 1, 3, 100, 500); compare("R2 code3", 1, 0, 0);
        done(0); compare("R2 soft after hard", 1, 4, 0);
        done(4); compare("R4", 1, 6, 0);
        done(6); compare("R4", 1, 3, 0);
        done(3); compare("R2 code3 is nrt", 1, 7, 0);
        done(7); compare("R3", 1, 1, 0);

        // R7, R8: sources, invalid entries, completion versus activation
        cfg(2, 0, 0, 0, 0);
        tmr_act = 8'b0000_0100; run_op("R7 invalid ignored"); compare("R7", 1, 1, 0);
        evt_act = 8'b0010_0000; run_op("R7 event"); compare("R7", 1, 1, 0);
        done(1); compare("R7 event arrival", 1, 5, 0);
        done_we = 1; done_id = 5; act_we = 1; act_id = 5;
        run_op("R8 act wins"); compare("R8", 1, 5, 0);
        cfg(5, 0, 0, 0, 0); compare("R10 idle after remove", 0, 0, 0);
        tmr_act = 8'b1000_0010; run_op("R6 same stamp"); compare("R6", 1, 1, 0);

        // R12, R13: semaphores
        sem_op("R12 take free", 0, 2, 3, 1, 4'b0100);
        sem_op("R12 take busy", 0, 2, 4, 0, 4'b0100);
        compare("R12 no block", 1, 1, 0);
        sem_op("R13 foreign give", 1, 2, 4, 0, 4'b0100);
        sem_op("R13 give free sem", 1, 0, 3, 0, 4'b0100);
        sem_op("R13 owner give", 1, 2, 3, 1, 4'b0000);

        // Sweep: random mixes of all table operations
        for (int s = 0; s < 1500; s++) begin
            r = next_rand();
            r2 = next_rand();
            cfg_we = (r[1:0] == 2'd0); cfg_id = r[4:2]; cfg_valid = (r[7:5] != 3'd0);
            cfg_class = r[9:8]; cfg_period = 16'(r[12:10]); cfg_deadline = 32'(r[15:13]);
            act_we = r[16]; act_id = r[19:17];
            done_we = r[20]; done_id = r[23:21];
            tmr_act = r2[7:0] & r2[15:8] & r2[23:16];
            evt_act = r2[31:24] & r[31:24] & r2[15:8];
            run_op("R9 R11 sweep");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule